// File: doc/BRIEF.md
# Four-Channel Wiper Register Slave on a Two-Wire Bus

This block is a two-wire (I2C) bus slave that holds four 8-bit wiper positions. It also holds one shutdown flag per channel and two general-purpose output levels. The block samples SCL and SDA with the system clock, which must be at least ten times faster than the bus clock. It works with standard-mode and fast-mode bus rates up to 400 kHz. SDA is modelled as an open-drain line: the block only asserts an output enable that pulls the line low.

A write transaction has three bytes: the device address, a command byte and an optional value byte. The command byte chooses a channel. It can return that channel to midscale, set or clear its shutdown flag, and load both output levels. The value byte then loads the chosen channel. A read transaction returns the position of the channel named by the most recent command byte.

Top module: `dpot_i2c_slave`

## Requirements
- R1: The device address is the 7-bit value `{5'b01011, strap_i[1], strap_i[0]}`, with the direction bit after it (0 = write, 1 = read). On a match, the slave drives SDA low for the ninth clock of the address byte. SDA is changed only while SCL is low.
- R2: After a non-matching address, the slave does not drive SDA and changes no state until the next START or STOP.
- R3: In a write, the second byte is the command byte. Bits [6:5] of the command byte select the channel (0..3), and bits 7 and 0 are don't-care. The third byte loads `wiper_o[8*ch +: 8]` of that channel.
- R4: Command bit 4 = 1 sets the selected channel's wiper to 0x80 when the command byte completes.
- R5: Command bit 3 copies into `shdn_o[ch]` of the selected channel, so the flag stays set until a command with bit 3 = 0 reaches that channel. This bit never alters any wiper value.
- R6: On every command byte, bit 2 is loaded into `gpo_o[1]` and bit 1 into `gpo_o[0]`.
- R7: In a read, after acknowledging the address, the slave shifts out MSB first the wiper of the channel selected by the last command byte. It then releases SDA for the master's acknowledge bit and for the rest of the transaction.
- R8: A STOP or repeated START anywhere in a transaction releases SDA and discards any partial byte without changing registers. A repeated START begins a new address phase.
- R9: After reset, all four wipers read 0x80, the shutdown flags and output levels are 0, the selected channel is 0, and SDA is released.
- R10: The command byte and the value byte are each acknowledged. Any byte after the value byte is not acknowledged and is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 2 | Low two bits of the device address |
| wiper_o | output | 32 | Four wiper positions, channel n at bits [8n+7:8n] |
| shdn_o | output | 4 | Per-channel shutdown flags |
| gpo_o | output | 2 | General-purpose output levels |

## Verification
The same command byte can set bit 4 and bit 3 together. The midscale reload and the shutdown flag then update the same channel on the same clock edge. The bench sends such a byte and requires both effects at once: the wiper reads 0x80 and the flag is set.

A second collision is a bus abort that lands while a byte is half shifted in. The bench issues a STOP after five command bits, and a repeated START after three value bits. Its per-clock reference model then requires every output to stay unchanged, and the following read to return the unchanged register.

// File: rtl/dpot_i2c_pkg.sv
package dpot_i2c_pkg;
  localparam int unsigned NUM_CH  = 4;
  localparam int unsigned CH_W    = $clog2(NUM_CH);
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned GPO_W   = 2;
  localparam int unsigned CNT_W   = $clog2(DATA_W + 2);
  localparam logic [4:0]  DEV_HI  = 5'b01011;
  localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_DATA, ST_READ, ST_SKIP
  } bus_state_e;

  typedef struct packed {
    logic [CH_W-1:0]  ch;
    logic             rst_mid;
    logic             shdn;
    logic [GPO_W-1:0] gpo;
  } instr_t;

  function automatic instr_t decode_instr(input logic [DATA_W-1:0] b);
    instr_t r;
    r.ch      = b[6:5];
    r.rst_mid = b[4];
    r.shdn    = b[3];
    r.gpo     = {b[2], b[1]};
    return r;
  endfunction
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync, scl_nxt, sda_nxt;
  logic scl_prev, sda_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      assign scl_nxt = scl_i;
      assign sda_nxt = sda_i;
    end else begin : g_chain
      assign scl_nxt = {scl_sync[SYNC_STAGES-2:0], scl_i};
      assign sda_nxt = {sda_sync[SYNC_STAGES-2:0], sda_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= scl_nxt;
      sda_sync <= sda_nxt;
      scl_prev <= scl_sync[SYNC_STAGES-1];
      sda_prev <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_sync[SYNC_STAGES-1];
  assign sda_o      = sda_sync[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  // SDA edge while SCL stays high
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/i2c_cmd_fsm.sv
module i2c_cmd_fsm
  import dpot_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        strap_i,
  input  logic [DATA_W-1:0] rd_byte_i,
  output logic              sda_oe_o,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] cmd_byte_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_byte_o
);
  bus_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q, tx_q;
  logic              ack_q, oe_q, rnw_q;
  logic              byte_done, addr_ok, rx_state;

  assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_INSTR) || (state_q == ST_DATA);
  assign byte_done = rx_state && scl_fall_i && !ack_q && (cnt_q == CNT_W'(DATA_W));
  assign addr_ok   = (shreg_q[DATA_W-1:1] == {DEV_HI, strap_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      tx_q    <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      rnw_q   <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_INSTR, ST_DATA: begin
          if (scl_rise_i && !ack_q && cnt_q != CNT_W'(DATA_W)) begin
            shreg_q <= {shreg_q[DATA_W-2:0], sda_lvl_i};
            cnt_q   <= cnt_q + 1'b1;
          end else if (scl_fall_i && ack_q) begin
            ack_q <= 1'b0;
            cnt_q <= '0;
            oe_q  <= 1'b0;
            unique case (state_q)
              ST_ADDR: begin
                if (rnw_q) begin
                  state_q <= ST_READ;
                  tx_q    <= rd_byte_i;
                  oe_q    <= ~rd_byte_i[DATA_W-1];
                end else begin
                  state_q <= ST_INSTR;
                end
              end
              ST_INSTR: state_q <= ST_DATA;
              default:  state_q <= ST_SKIP;
            endcase
          end else if (byte_done) begin
            if (state_q == ST_ADDR && !addr_ok) begin
              state_q <= ST_SKIP;
            end else begin
              ack_q <= 1'b1;
              oe_q  <= 1'b1;
              if (state_q == ST_ADDR) rnw_q <= shreg_q[0];
            end
          end
        end
        ST_READ: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall_i) begin
            if (cnt_q == CNT_W'(DATA_W)) begin
              oe_q    <= 1'b0;
              state_q <= ST_SKIP;
            end else begin
              tx_q <= {tx_q[DATA_W-2:0], 1'b0};
              oe_q <= ~tx_q[DATA_W-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o    = oe_q;
  assign cmd_valid_o = byte_done && (state_q == ST_INSTR);
  assign wr_valid_o  = byte_done && (state_q == ST_DATA);
  assign cmd_byte_o  = shreg_q;
  assign wr_byte_o   = shreg_q;

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_lvl_i);  // R1
  AST_SKIP_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> !oe_q);  // R2
  AST_ABORT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> !oe_q);  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);  // R9
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import dpot_i2c_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_valid_i,
  input  logic [DATA_W-1:0]        cmd_byte_i,
  input  logic                     wr_valid_i,
  input  logic [DATA_W-1:0]        wr_byte_i,
  output logic [NUM_CH*DATA_W-1:0] wiper_o,
  output logic [NUM_CH-1:0]        shdn_o,
  output logic [GPO_W-1:0]         gpo_o,
  output logic [DATA_W-1:0]        rd_byte_o
);
  instr_t            ins;
  logic [CH_W-1:0]   sel_q;
  logic [GPO_W-1:0]  gpo_q;
  logic [DATA_W-1:0] wiper_q [NUM_CH];
  logic [NUM_CH-1:0] shdn_q;

  assign ins = decode_instr(cmd_byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      gpo_q <= '0;
    end else if (cmd_valid_i) begin
      sel_q <= ins.ch;
      gpo_q <= ins.gpo;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wiper_q[g] <= MIDSCALE;
        shdn_q[g]  <= 1'b0;
      end else if (cmd_valid_i && ins.ch == CH_W'(g)) begin
        if (ins.rst_mid) wiper_q[g] <= MIDSCALE;
        shdn_q[g] <= ins.shdn;
      end else if (wr_valid_i && sel_q == CH_W'(g)) begin
        wiper_q[g] <= wr_byte_i;
      end
    end
    assign wiper_o[g*DATA_W +: DATA_W] = wiper_q[g];

    AST_RS_MIDSCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && ins.rst_mid && ins.ch == CH_W'(g)) |=> (wiper_q[g] == MIDSCALE));  // R4
    AST_SD_KEEPS_WIPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && !ins.rst_mid) |=> $stable(wiper_q[g]));  // R5
    AST_SD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cmd_valid_i |=> $stable(shdn_q[g]));  // R5
  end

  assign shdn_o    = shdn_q;
  assign gpo_o     = gpo_q;
  assign rd_byte_o = wiper_q[sel_q];
endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave
  import dpot_i2c_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe_o,
  input  logic [1:0]               strap_i,
  output logic [NUM_CH*DATA_W-1:0] wiper_o,
  output logic [NUM_CH-1:0]        shdn_o,
  output logic [GPO_W-1:0]         gpo_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic cmd_valid, wr_valid;
  logic [DATA_W-1:0] cmd_byte, wr_byte, rd_byte;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) i_line (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_lvl), .sda_o(sda_lvl),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  i2c_cmd_fsm i_fsm (
    .clk_i, .rst_ni,
    .scl_lvl_i(scl_lvl), .sda_lvl_i(sda_lvl),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt),
    .strap_i, .rd_byte_i(rd_byte),
    .sda_oe_o,
    .cmd_valid_o(cmd_valid), .cmd_byte_o(cmd_byte),
    .wr_valid_o(wr_valid), .wr_byte_o(wr_byte)
  );

  wiper_bank i_bank (
    .clk_i, .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte),
    .wr_valid_i(wr_valid), .wr_byte_i(wr_byte),
    .wiper_o, .shdn_o, .gpo_o, .rd_byte_o(rd_byte)
  );

  AST_ONE_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid && wr_valid));  // R3
endmodule

// File: tb/test_dpot_i2c_slave.sv
`timescale 1ns/1ps
module test_dpot_i2c_slave;
  localparam int Q = 10;
  localparam logic [4:0] HI = 5'b01011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_low = 1'b0;
  logic sda, sda_oe;
  logic [1:0] strap = 2'b10;
  logic [31:0] wiper;
  logic [3:0] shdn;
  logic [1:0] gpo;

  assign sda = ~(m_low | sda_oe);
  always #2.5 clk = ~clk;

  dpot_i2c_slave i_dpot_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe_o(sda_oe),
    .strap_i(strap), .wiper_o(wiper), .shdn_o(shdn), .gpo_o(gpo)
  );

  int checks = 0, errors = 0;
  int exp_w [4];
  bit exp_sd [4];
  bit [1:0] exp_gpo;
  int exp_sel;
  bit busy = 1'b1, mon_on = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !busy && mon_on) begin
      for (int c = 0; c < 4; c++) begin
        chk(wiper[8*c +: 8] == exp_w[c][7:0], "R3 model wiper", wiper[8*c +: 8], exp_w[c]);
        chk(shdn[c] == exp_sd[c], "R5 model shdn", shdn[c], exp_sd[c]);
      end
      chk(gpo == exp_gpo, "R6 model gpo", gpo, exp_gpo);
      if (errors > 20) mon_on = 1'b0;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic start_c;
    m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b1; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic stop_c;
    m_low = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b0; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_low = ~b[i]; wq(Q); scl = 1'b1; wq(2*Q);
      if (i == 0) busy = 1'b1;
      scl = 1'b0; wq(Q);
    end
  endtask

  task automatic read_bit(output bit v);
    m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); v = sda; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic read_ack(output bit a);
    bit v;
    read_bit(v);
    a = ~v;
  endtask

  function automatic logic [7:0] mk_ins(input int ch, input bit rs, input bit sd,
                                        input bit o1, input bit o2);
    return {1'b1, ch[1:0], rs, sd, o1, o2, 1'b1};
  endfunction

  task automatic model_ins(input logic [7:0] b);
    exp_sel = b[6:5];
    if (b[4]) exp_w[exp_sel] = 8'h80;
    exp_sd[exp_sel] = b[3];
    exp_gpo = {b[2], b[1]};
  endtask

  task automatic wr_txn(input logic [7:0] ins, input bit has_data, input logic [7:0] dat,
                        input bit extra);
    bit a;
    start_c;
    send_bits({HI, strap, 1'b0}, 8); busy = 1'b0;
    read_ack(a); chk(a, "R1 write address ack", a, 1);
    send_bits(ins, 8); model_ins(ins); busy = 1'b0;
    read_ack(a); chk(a, "R10 command ack", a, 1);
    if (has_data) begin
      send_bits(dat, 8); exp_w[exp_sel] = dat; busy = 1'b0;
      read_ack(a); chk(a, "R10 value ack", a, 1);
      if (extra) begin
        send_bits(8'h5A, 8); busy = 1'b0;
        read_ack(a); chk(!a, "R10 extra byte nack", a, 0);
      end
    end
    stop_c;
  endtask

  task automatic rd_txn(input bit mack);
    bit a, v;
    logic [7:0] got;
    start_c;
    send_bits({HI, strap, 1'b1}, 8); busy = 1'b0;
    read_ack(a); chk(a, "R1 read address ack", a, 1);
    for (int i = 7; i >= 0; i--) begin
      read_bit(v);
      got[i] = v;
    end
    chk(got == exp_w[exp_sel][7:0], "R7 read data", got, exp_w[exp_sel]);
    m_low = mack; wq(Q); scl = 1'b1; wq(Q);
    chk(!sda_oe, "R7 released in master ack bit", sda_oe, 0);
    wq(Q); scl = 1'b0; wq(Q);
    stop_c;
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < 4; c++)
      chk(wiper[8*c +: 8] == exp_w[c][7:0], tag, wiper[8*c +: 8], exp_w[c]);
    for (int c = 0; c < 4; c++)
      chk(shdn[c] == exp_sd[c], tag, shdn[c], exp_sd[c]);
    chk(gpo == exp_gpo, tag, gpo, exp_gpo);
    chk(!sda_oe, tag, sda_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all R) actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit a;
    for (int c = 0; c < 4; c++) begin
      exp_w[c] = 8'h80;
      exp_sd[c] = 1'b0;
    end
    exp_gpo = 2'b00;
    exp_sel = 0;
    wq(5); rst_n = 1'b1; wq(5);
    check_all("R9 reset state");
    busy = 1'b0;

    wr_txn(mk_ins(2, 0, 0, 1, 0), 1, 8'h3C, 0);          // R3 R6
    wr_txn(mk_ins(0, 0, 0, 0, 1), 1, 8'hF1, 0);
    rd_txn(1'b0);                                          // R7 channel 0
    wr_txn(mk_ins(2, 1, 0, 1, 1), 0, 8'h00, 0);          // R4
    check_all("R4 midscale reload");
    wr_txn(mk_ins(1, 0, 1, 0, 0), 1, 8'h11, 0);          // R5 set, value still loads
    check_all("R5 shutdown set keeps value");
    wr_txn(mk_ins(3, 1, 1, 0, 1), 0, 8'h00, 0);          // R4+R5 same cycle
    check_all("R5 R4 combined command");
    wr_txn(mk_ins(1, 0, 0, 0, 0), 0, 8'h00, 0);          // R5 clear
    check_all("R5 shutdown cleared");
    rd_txn(1'b1);                                          // R7 channel 1

    // R2 wrong strap bits, then wrong upper bits
    start_c;
    send_bits({HI, ~strap, 1'b0}, 8); busy = 1'b0;
    read_ack(a); chk(!a, "R2 mismatch nack", a, 0);
    send_bits(mk_ins(0, 1, 1, 1, 1), 8); busy = 1'b0;
    read_ack(a); chk(!a, "R2 ignored byte", a, 0);
    stop_c;
    start_c;
    send_bits({5'b11011, strap, 1'b0}, 8); busy = 1'b0;
    read_ack(a); chk(!a, "R2 upper mismatch nack", a, 0);
    stop_c;
    check_all("R2 no change after mismatch");

    wr_txn(mk_ins(0, 0, 0, 1, 1), 1, 8'h07, 1);          // R10 extra byte
    check_all("R10 extra byte ignored");

    // R8 STOP inside command byte
    start_c;
    send_bits({HI, strap, 1'b0}, 8); busy = 1'b0;
    read_ack(a); chk(a, "R1 address ack", a, 1);
    send_bits(mk_ins(2, 1, 1, 0, 0), 5);
    stop_c;
    check_all("R8 stop aborts command");

    // R8 repeated START inside value byte, then read
    start_c;
    send_bits({HI, strap, 1'b0}, 8); busy = 1'b0;
    read_ack(a); chk(a, "R1 address ack", a, 1);
    send_bits(mk_ins(3, 0, 0, 1, 0), 8); model_ins(mk_ins(3, 0, 0, 1, 0)); busy = 1'b0;
    read_ack(a); chk(a, "R10 command ack", a, 1);
    send_bits(8'h00, 3);
    rd_txn(1'b0);                                          // R8 R7
    check_all("R8 repeated start aborts value");

    // R1 new strap value
    strap = 2'b01;
    wr_txn(mk_ins(3, 0, 0, 0, 0), 1, 8'hC3, 0);
    rd_txn(1'b0);
    check_all("R1 strap change");

    wq(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule